// File: doc/BRIEF.md
# Memory Sleep Entry and Recovery Controller

This block sits between the access-request pins of a synchronous memory and its core. It manages a low-power sleep state that an external pin requests without reference to the clock. The request passes through a synchroniser. A counter-driven state machine then moves through a timed entry phase into sleep, and later through a timed recovery phase back to normal operation. While the controller is entering, asleep or recovering, it forces the chip selects and address strobes that reach the core to zero. During entry it raises an abort flag, which tells the core that any access still in flight is void.

The block drives three status outputs. `sleep_active` gates the clock or power of the core. `ready` tells upstream logic that accesses may resume. `err` is a one-cycle error pulse. It fires when a select or strobe is still asserted in the cycle where sleep is decided, or when one is asserted during the recovery window. Upstream logic must drop all selects before it requests sleep and must keep them low until `ready` returns.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: `sleep_req` passes through a two-stage synchroniser. A level driven before clock edge k first changes the state machine at edge k+2, so `ready` is still 1 after edges k and k+1.
- R2: Once sleep is decided, the controller spends exactly ENTRY_CYC cycles (default 2) in the entry phase. `abort_pending` is 1 in those cycles and 0 in every other state.
- R3: `sleep_active` is 1 only in the sleep state. It rises in the cycle after the last entry cycle and stays 1 for as long as the synchronised request remains high.
- R4: After the synchronised request falls, the controller spends exactly EXIT_CYC cycles (default 2) in recovery, with `ready`, `sleep_active` and `abort_pending` all 0. `ready` returns to 1 in the cycle after that.
- R5: After synchronous reset, `ready`=1 and `sleep_active`, `abort_pending` and `err` are all 0. `ready` is 1 only in the awake state.
- R6: `sel_gated` and `stb_gated` equal `chip_sel` and `addr_stb` (bit for bit, active high) while `ready`=1. In every other state they are all zero.
- R7: If any `chip_sel` or `addr_stb` bit is 1 in the cycle where an awake controller sees the synchronised request, `err` is 1 in the following cycle.
- R8: If any `chip_sel` or `addr_stb` bit is 1 during a recovery cycle, `err` is 1 in the following cycle.
- R9: Selects and strobes that are active while awake, during the entry phase after the deciding cycle, or while asleep do not raise `err`.
- R10: An entry that has started always runs to the sleep state, even if the request drops during entry. Recovery then follows as soon as the synchronised low request is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| chip_sel | input | NUM_SEL | Chip selects from upstream, active high |
| addr_stb | input | NUM_STB | Address strobes from upstream, active high |
| sel_gated | output | NUM_SEL | Chip selects passed to the core |
| stb_gated | output | NUM_STB | Address strobes passed to the core |
| sleep_active | output | 1 | Core is in sleep |
| ready | output | 1 | Accesses may be issued |
| abort_pending | output | 1 | Entry phase: in-flight access is void |
| err | output | 1 | Protocol violation pulse |

## Verification
The bench builds two instances on shared stimulus. The first uses the defaults: two entry cycles, two recovery cycles, three selects and two strobes, which reproduce the two-cycle figures exactly. The second uses three entry cycles, four recovery cycles and three selects. With unequal, longer windows, an off-by-one in the counter load, or a swap of the entry and exit lengths, shows up as a shifted edge on `sleep_active` or `ready`.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_ENTERING = 2'd1,
        ST_ASLEEP   = 2'd2,
        ST_EXITING  = 2'd3
    } slp_state_e;

    typedef struct packed {
        logic ready;
        logic asleep;
        logic abort;
        logic recover;
    } slp_flags_t;

    function automatic slp_flags_t decode_state(input slp_state_e s);
        slp_flags_t f;
        f.ready   = (s == ST_AWAKE);
        f.asleep  = (s == ST_ASLEEP);
        f.abort   = (s == ST_ENTERING);
        f.recover = (s == ST_EXITING);
        return f;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lp_sleep_fsm.sv
module lp_sleep_fsm
    import lp_sleep_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_s,
    output slp_flags_t flags
);
    localparam int MAXC = max2(ENTRY_CYC, EXIT_CYC);
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    slp_state_e    state, nstate;
    logic [CW-1:0] cnt, ncnt;

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        case (state)
            ST_AWAKE: if (req_s) begin
                nstate = ST_ENTERING;
                ncnt   = CW'(ENTRY_CYC - 1);
            end
            ST_ENTERING: begin
                if (cnt == '0) nstate = ST_ASLEEP;
                else           ncnt   = cnt - CW'(1);
            end
            ST_ASLEEP: if (!req_s) begin
                nstate = ST_EXITING;
                ncnt   = CW'(EXIT_CYC - 1);
            end
            default: begin
                if (cnt == '0) nstate = ST_AWAKE;
                else           ncnt   = cnt - CW'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    assign flags = decode_state(state);
endmodule

// File: rtl/lp_access_gate.sv
module lp_access_gate
    import lp_sleep_pkg::*;
#(
    parameter int NUM_SEL = 3,
    parameter int NUM_STB = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  slp_flags_t         flags,
    input  logic               req_s,
    input  logic [NUM_SEL-1:0] chip_sel,
    input  logic [NUM_STB-1:0] addr_stb,
    output logic [NUM_SEL-1:0] sel_gated,
    output logic [NUM_STB-1:0] stb_gated,
    output logic               err
);
    logic any_active;
    logic violation;

    assign any_active = (|chip_sel) | (|addr_stb);
    assign violation  = any_active & ((flags.ready & req_s) | flags.recover);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel_gated[i] = chip_sel[i] & flags.ready;
    end
    for (genvar j = 0; j < NUM_STB; j++) begin : g_stb
        assign stb_gated[j] = addr_stb[j] & flags.ready;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= violation;
    end
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
    import lp_sleep_pkg::*;
#(
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int NUM_SEL     = 3,
    parameter int NUM_STB     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic [NUM_SEL-1:0] chip_sel,
    input  logic [NUM_STB-1:0] addr_stb,
    output logic [NUM_SEL-1:0] sel_gated,
    output logic [NUM_STB-1:0] stb_gated,
    output logic               sleep_active,
    output logic               ready,
    output logic               abort_pending,
    output logic               err
);
    logic       req_s;
    slp_flags_t flags;

    lp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sleep_req),
        .q   (req_s)
    );

    lp_sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .req_s (req_s),
        .flags (flags)
    );

    lp_access_gate #(.NUM_SEL(NUM_SEL), .NUM_STB(NUM_STB)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .flags     (flags),
        .req_s     (req_s),
        .chip_sel  (chip_sel),
        .addr_stb  (addr_stb),
        .sel_gated (sel_gated),
        .stb_gated (stb_gated),
        .err       (err)
    );

    assign sleep_active  = flags.asleep;
    assign ready         = flags.ready;
    assign abort_pending = flags.abort;
endmodule

// File: rtl/lp_sleep_ctrl_chk.sv
module lp_sleep_ctrl_chk #(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int NUM_SEL   = 3,
    parameter int NUM_STB   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SEL-1:0] sel_gated,
    input logic [NUM_STB-1:0] stb_gated,
    input logic               sleep_active,
    input logic               ready,
    input logic               abort_pending
);
    logic [15:0] entry_run, exit_run;
    logic        in_recovery;

    assign in_recovery = !ready && !sleep_active && !abort_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_run <= '0;
            exit_run  <= '0;
        end else begin
            entry_run <= abort_pending ? entry_run + 16'd1 : 16'd0;
            exit_run  <= in_recovery   ? exit_run  + 16'd1 : 16'd0;
        end
    end

    // R5: the status outputs never overlap
    assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ready, sleep_active, abort_pending}));

    // R2: the entry phase never runs past its length
    assert_entry_len_R2: assert property (@(posedge clk) disable iff (rst)
        abort_pending |-> (entry_run < 16'(ENTRY_CYC)));

    // R10: the entry phase always ends in sleep
    assert_entry_completes_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(abort_pending) |-> sleep_active);

    // R3: sleep is reached only through the entry phase
    assert_sleep_via_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_active) |-> $past(abort_pending));

    // R4: the recovery phase never runs past its length
    assert_exit_len_R4: assert property (@(posedge clk) disable iff (rst)
        in_recovery |-> (exit_run < 16'(EXIT_CYC)));

    // R6: nothing reaches the core while asleep
    assert_blocked_asleep_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_active |-> (sel_gated == '0 && stb_gated == '0));
endmodule

bind lp_sleep_ctrl lp_sleep_ctrl_chk #(
    .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .NUM_SEL(NUM_SEL), .NUM_STB(NUM_STB)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sel_gated     (sel_gated),
    .stb_gated     (stb_gated),
    .sleep_active  (sleep_active),
    .ready         (ready),
    .abort_pending (abort_pending)
);

// File: tb/lp_sleep_ctrl_test.sv
module lp_sleep_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [2:0] chip_sel = '0;
    logic [1:0] addr_stb = '0;

    logic [2:0] sel_g, sel_g_w;
    logic [1:0] stb_g, stb_g_w;
    logic       slp, rdy, abt, er;
    logic       slp_w, rdy_w, abt_w, er_w;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lp_sleep_ctrl uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .chip_sel(chip_sel), .addr_stb(addr_stb),
        .sel_gated(sel_g), .stb_gated(stb_g),
        .sleep_active(slp), .ready(rdy), .abort_pending(abt), .err(er)
    );

    lp_sleep_ctrl #(.ENTRY_CYC(3), .EXIT_CYC(4), .NUM_SEL(3), .NUM_STB(2)) uut_w (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .chip_sel(chip_sel), .addr_stb(addr_stb),
        .sel_gated(sel_g_w), .stb_gated(stb_g_w),
        .sleep_active(slp_w), .ready(rdy_w), .abort_pending(abt_w), .err(er_w)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);
        check("R5 reset ready",  {7'd0, rdy}, 8'd1);
        check("R5 reset sleep",  {7'd0, slp}, 8'd0);
        check("R5 reset abort",  {7'd0, abt}, 8'd0);
        check("R5 reset err",    {7'd0, er},  8'd0);
    endtask

    task automatic t_enter();
        sleep_req = 1'b1;
        step(2);
        check("R1 ready before sync", {7'd0, rdy}, 8'd1);
        step(1);
        check("R1 leaves awake",  {7'd0, rdy}, 8'd0);
        check("R2 abort cycle 1", {7'd0, abt}, 8'd1);
        step(1);
        check("R2 abort cycle 2", {7'd0, abt}, 8'd1);
        check("R2 not yet asleep", {7'd0, slp}, 8'd0);
        step(1);
        check("R3 asleep", {7'd0, slp}, 8'd1);
        check("R2 abort cleared", {7'd0, abt}, 8'd0);
        step(4);
        check("R3 stays asleep", {7'd0, slp}, 8'd1);
    endtask

    task automatic t_exit();
        sleep_req = 1'b0;
        step(2);
        check("R4 sleep held during sync", {7'd0, slp}, 8'd1);
        step(1);
        check("R4 recovery sleep off", {7'd0, slp}, 8'd0);
        check("R4 recovery not ready", {7'd0, rdy}, 8'd0);
        step(1);
        check("R4 recovery cycle 2", {7'd0, rdy}, 8'd0);
        step(1);
        check("R4 ready again", {7'd0, rdy}, 8'd1);
        step(4);
    endtask

    task automatic t_gating();
        chip_sel = 3'b101;
        addr_stb = 2'b10;
        #1;
        check("R6 sel pass awake", {5'd0, sel_g}, 8'h05);
        check("R6 stb pass awake", {6'd0, stb_g}, 8'h02);
        step(2);
        check("R9 no err awake", {7'd0, er}, 8'd0);
        chip_sel = '0;
        addr_stb = '0;
        t_enter();
        chip_sel = 3'b111;
        addr_stb = 2'b11;
        #1;
        check("R6 sel blocked asleep", {5'd0, sel_g}, 8'h00);
        check("R6 stb blocked asleep", {6'd0, stb_g}, 8'h00);
        step(3);
        check("R9 no err asleep", {7'd0, er}, 8'd0);
        chip_sel = '0;
        addr_stb = '0;
        t_exit();
    endtask

    task automatic t_err_entry();
        chip_sel = 3'b010;
        sleep_req = 1'b1;
        step(2);
        check("R7 no err before decision", {7'd0, er}, 8'd0);
        step(1);
        check("R7 err on select at entry", {7'd0, er}, 8'd1);
        step(1);
        check("R9 no err inside entry", {7'd0, er}, 8'd0);
        chip_sel = '0;
        step(4);
        check("R3 asleep after flagged entry", {7'd0, slp}, 8'd1);
        t_exit();
    endtask

    task automatic t_err_recover();
        t_enter();
        sleep_req = 1'b0;
        step(3);
        addr_stb = 2'b01;
        step(1);
        check("R8 err on strobe in recovery", {7'd0, er}, 8'd1);
        addr_stb = '0;
        step(1);
        check("R8 err clears", {7'd0, er}, 8'd0);
        check("R4 ready after recovery", {7'd0, rdy}, 8'd1);
        step(4);
    endtask

    task automatic t_abandon();
        sleep_req = 1'b1;
        step(3);
        sleep_req = 1'b0;
        step(1);
        check("R10 entry continues", {7'd0, abt}, 8'd1);
        step(1);
        check("R10 reaches sleep", {7'd0, slp}, 8'd1);
        step(1);
        check("R10 recovery follows", {7'd0, slp | rdy}, 8'd0);
        step(2);
        check("R10 ready after recovery", {7'd0, rdy}, 8'd1);
        step(6);
    endtask

    task automatic t_wide();
        step(10);
        check("R5 wide awake", {7'd0, rdy_w}, 8'd1);
        sleep_req = 1'b1;
        step(3);
        check("R2 wide abort start", {7'd0, abt_w}, 8'd1);
        step(2);
        check("R2 wide abort cycle 3", {7'd0, abt_w}, 8'd1);
        check("R2 wide not asleep", {7'd0, slp_w}, 8'd0);
        step(1);
        check("R3 wide asleep", {7'd0, slp_w}, 8'd1);
        sleep_req = 1'b0;
        step(3);
        check("R4 wide recovery", {7'd0, rdy_w | slp_w}, 8'd0);
        step(3);
        check("R4 wide recovery cycle 4", {7'd0, rdy_w}, 8'd0);
        step(1);
        check("R4 wide ready", {7'd0, rdy_w}, 8'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_enter();
        t_exit();
        t_gating();
        t_err_entry();
        t_err_recover();
        t_abandon();
        t_wide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule